// File: doc/BRIEF.md
# Merged Asian-Barrier Payoff Evaluator

This block sits at the end of a Monte Carlo option-pricing pipeline. It receives simulated underlying prices as a stream, one price per time step, path after path. From one pass over each path it forms two payoffs. The first is a call on the arithmetic mean of the path, the Asian payoff. The second is an up-and-in barrier call on the final price, which only pays if the path touched the barrier. Both payoffs are added into their own wide accumulators, and a path counter runs beside them. Discounting and the division of the sums by the path count happen outside the block.

The strike, the barrier level and the reciprocal of the step count are runtime inputs. The step count is used only as a reciprocal, so the mean needs one multiply and no divider. A marker on the last step closes a path. A second marker on that same step closes the batch. When the batch closes, a one-cycle done pulse comes out with the final sums. The next path that closes starts a new batch.

Top module: `asian_barrier_payoff`

## Requirements
- R1: A price is accepted on every clock cycle in which `priceValid` is high, with no stall. Paths may follow each other with no idle cycle. Cycles with `priceValid` low leave the open path unchanged.
- R2: Prices are unsigned Q16.16. The path sum is 48 bits wide and holds every step price of the path. The mean is floor(sum × `avgRecip` / 2^32), where `avgRecip` is an unsigned Q0.32 reciprocal of the step count. The result is truncated to 32 bits.
- R3: A path counts as having hit the barrier if any of its step prices, the last step included, is greater than or equal to `barrier`. The hit state is cleared at the first step of every path and never carries from one path to the next.
- R4: The Asian payoff of a path is the mean minus `strike` when the mean is greater than `strike`, and zero otherwise.
- R5: The barrier payoff of a path is the final price minus `strike` when the path hit the barrier and the final price is greater than `strike`. It is zero in every other case, and in particular whenever the path did not hit the barrier.
- R6: A path closes at the step that carries `lastStep`. The step after a closing step is the first step of a new path.
- R7: Each closed path adds its Asian payoff to `asianSum`, its barrier payoff to `barrierSum`, and one to `pathCount`. These outputs change on the second clock edge after the edge that accepted the closing step.
- R8: A closing step that also carries `lastPath` ends the batch. `batchDone` is then high for exactly one cycle, in the same cycle as that path's totals. The next path to close replaces the sums with its own payoffs and sets `pathCount` to 1.
- R9: `asianSum`, `barrierSum` and `pathCount` hold their values in every cycle in which no path's totals are being added.
- R10: After reset all outputs are zero. The next accepted price is the first step of a path, and the first path to close starts a fresh batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| priceValid | input | 1 | A price step is presented this cycle |
| price | input | 32 | Underlying price, unsigned Q16.16 |
| lastStep | input | 1 | This step closes the current path |
| lastPath | input | 1 | With lastStep: this path closes the batch |
| strike | input | 32 | Strike level, Q16.16 |
| barrier | input | 32 | Up-and-in barrier level, Q16.16 |
| avgRecip | input | 32 | Reciprocal of the step count, Q0.32 |
| asianSum | output | 64 | Sum of Asian payoffs in the batch, Q16.16 |
| barrierSum | output | 64 | Sum of barrier payoffs in the batch, Q16.16 |
| pathCount | output | 32 | Number of paths closed in the batch |
| batchDone | output | 1 | One-cycle pulse when the batch closes |

## Verification
The bound checker watches several things on every cycle. It checks that the hit state stays set for the rest of a path and is set by any price at or above the barrier. It checks that a path without a hit yields a zero barrier payoff, and that the Asian payoff never exceeds the mean it was formed from. It also checks the counter's step-by-one and restart-to-one behaviour, that the sums hold when nothing is added, and that the done pulse comes only with an addition. Other behaviours need the bench's scenarios. Among them are the exact payoff values, the truncation of the reciprocal mean over a 252-step path, a barrier touched exactly, the hit state not leaking into the next path, idle cycles inside a path, and the totals of a multi-path batch. The bench checks these against its behavioural model and against hand-computed values.

// File: rtl/payoff_pkg.sv
package payoff_pkg;

  // Default widths shared by the evaluator and its checker
  parameter int PRICE_W = 32;  // Q16.16 price
  parameter int SUM_W   = 48;  // running path sum
  parameter int RECIP_W = 32;  // Q0.32 reciprocal of the step count
  parameter int ACC_W   = 64;  // batch payoff accumulators
  parameter int CNT_W   = 32;  // path counter

  // Strobes from the control into the datapath
  typedef struct packed {
    logic stepLoad;   // a price step is accepted
    logic stepFirst;  // the accepted step opens a path
    logic closeLoad;  // the accepted step closes the path
    logic payLoad;    // payoff stage registers load
    logic accLoad;    // accumulators take the payoffs
    logic accClear;   // the accumulation starts a new batch
  } strobes_t;

endpackage

// File: rtl/payoff_ctrl.sv
module payoff_ctrl
  import payoff_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     priceValid,
  input  logic     lastStep,
  input  logic     lastPath,
  output strobes_t strobes,
  output logic     batchDone
);

  logic firstStepR;   // next accepted price opens a path
  logic closeQ;       // closing data sits in the stage-1 registers
  logic lastPathQ1;   // that closing path ends the batch
  logic payQ;         // payoffs sit in the stage-2 registers
  logic lastPathQ2;
  logic freshR;       // next accumulation starts a new batch

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstStepR <= 1'b1;
      closeQ     <= 1'b0;
      lastPathQ1 <= 1'b0;
      payQ       <= 1'b0;
      lastPathQ2 <= 1'b0;
      freshR     <= 1'b1;
      batchDone  <= 1'b0;
    end else begin
      if (priceValid) firstStepR <= lastStep;
      closeQ     <= priceValid & lastStep;
      lastPathQ1 <= priceValid & lastStep & lastPath;
      payQ       <= closeQ;
      lastPathQ2 <= lastPathQ1;
      batchDone  <= payQ & lastPathQ2;
      if (payQ) freshR <= lastPathQ2;
    end
  end

  always_comb begin
    strobes.stepLoad  = priceValid;
    strobes.stepFirst = firstStepR;
    strobes.closeLoad = priceValid & lastStep;
    strobes.payLoad   = closeQ;
    strobes.accLoad   = payQ;
    strobes.accClear  = freshR;
  end

endmodule

// File: rtl/payoff_datapath.sv
module payoff_datapath
  import payoff_pkg::*;
#(
  parameter int PW = PRICE_W,
  parameter int SW = SUM_W,
  parameter int RW = RECIP_W,
  parameter int AW = ACC_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strobes,
  input  logic [PW-1:0] price,
  input  logic [PW-1:0] strike,
  input  logic [PW-1:0] barrier,
  input  logic [RW-1:0] avgRecip,
  output logic          hitFlag,
  output logic [PW-1:0] avgVal,
  output logic          closeHit,
  output logic [PW-1:0] asianPay,
  output logic [PW-1:0] barrierPay,
  output logic [AW-1:0] asianSum,
  output logic [AW-1:0] barrierSum,
  output logic [CW-1:0] pathCount
);

  localparam int PROD_W = SW + RW;

  // Stage 0: running sum and sticky hit state of the open path
  logic [SW-1:0] runSum;
  logic [SW-1:0] sumNext;
  logic          hitNext;

  always_comb begin
    sumNext = (strobes.stepFirst ? '0 : runSum) + SW'(price);
    hitNext = (strobes.stepFirst ? 1'b0 : hitFlag) | (price >= barrier);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runSum  <= '0;
      hitFlag <= 1'b0;
    end else if (strobes.stepLoad) begin
      runSum  <= sumNext;
      hitFlag <= hitNext;
    end
  end

  // Stage 1: captured totals of the path that just closed
  logic [SW-1:0] closeSum;
  logic [PW-1:0] closePrice;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      closeSum   <= '0;
      closeHit   <= 1'b0;
      closePrice <= '0;
    end else if (strobes.closeLoad) begin
      closeSum   <= sumNext;
      closeHit   <= hitNext;
      closePrice <= price;
    end
  end

  // Stage 2: mean through the reciprocal, then both payoffs
  logic [PROD_W-1:0] avgProd;
  logic [PW-1:0]     asianNext;
  logic [PW-1:0]     barrierNext;

  always_comb begin
    avgProd     = PROD_W'(closeSum) * PROD_W'(avgRecip);
    avgVal      = PW'(avgProd >> RW);
    asianNext   = (avgVal > strike) ? (avgVal - strike) : '0;
    barrierNext = (closeHit && (closePrice > strike)) ? (closePrice - strike) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asianPay   <= '0;
      barrierPay <= '0;
    end else if (strobes.payLoad) begin
      asianPay   <= asianNext;
      barrierPay <= barrierNext;
    end
  end

  // Stage 3: batch accumulators
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asianSum   <= '0;
      barrierSum <= '0;
      pathCount  <= '0;
    end else if (strobes.accLoad) begin
      if (strobes.accClear) begin
        asianSum   <= AW'(asianPay);
        barrierSum <= AW'(barrierPay);
        pathCount  <= CW'(1);
      end else begin
        asianSum   <= asianSum + AW'(asianPay);
        barrierSum <= barrierSum + AW'(barrierPay);
        pathCount  <= pathCount + CW'(1);
      end
    end
  end

endmodule

// File: rtl/asian_barrier_payoff.sv
module asian_barrier_payoff
  import payoff_pkg::*;
#(
  parameter int PW = PRICE_W,
  parameter int SW = SUM_W,
  parameter int RW = RECIP_W,
  parameter int AW = ACC_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          priceValid,
  input  logic [PW-1:0] price,
  input  logic          lastStep,
  input  logic          lastPath,
  input  logic [PW-1:0] strike,
  input  logic [PW-1:0] barrier,
  input  logic [RW-1:0] avgRecip,
  output logic [AW-1:0] asianSum,
  output logic [AW-1:0] barrierSum,
  output logic [CW-1:0] pathCount,
  output logic          batchDone
);

  strobes_t      strobes;
  logic          hitFlag;
  logic [PW-1:0] avgVal;
  logic          closeHit;
  logic [PW-1:0] asianPay;
  logic [PW-1:0] barrierPay;

  payoff_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .priceValid (priceValid),
    .lastStep   (lastStep),
    .lastPath   (lastPath),
    .strobes    (strobes),
    .batchDone  (batchDone)
  );

  payoff_datapath #(
    .PW (PW), .SW (SW), .RW (RW), .AW (AW), .CW (CW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .price      (price),
    .strike     (strike),
    .barrier    (barrier),
    .avgRecip   (avgRecip),
    .hitFlag    (hitFlag),
    .avgVal     (avgVal),
    .closeHit   (closeHit),
    .asianPay   (asianPay),
    .barrierPay (barrierPay),
    .asianSum   (asianSum),
    .barrierSum (barrierSum),
    .pathCount  (pathCount)
  );

endmodule

// File: rtl/payoff_checker.sv
module payoff_checker
  import payoff_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [PRICE_W-1:0] price,
  input logic [PRICE_W-1:0] barrier,
  input strobes_t           strobes,
  input logic               hitFlag,
  input logic [PRICE_W-1:0] avgVal,
  input logic               closeHit,
  input logic [PRICE_W-1:0] asianPay,
  input logic [PRICE_W-1:0] barrierPay,
  input logic [ACC_W-1:0]   asianSum,
  input logic [ACC_W-1:0]   barrierSum,
  input logic [CNT_W-1:0]   pathCount,
  input logic               batchDone
);

  assert_hit_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepLoad && (price >= barrier)) |=> hitFlag);

  assert_hit_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepLoad && !strobes.stepFirst && hitFlag) |=> hitFlag);

  assert_asian_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.payLoad |=> (asianPay <= $past(avgVal)));

  assert_no_hit_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.payLoad && !closeHit) |=> (barrierPay == '0));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accLoad && !strobes.accClear) |=> (pathCount == $past(pathCount) + 1'b1));

  assert_count_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accLoad && strobes.accClear) |=> (pathCount == 1));

  assert_done_with_add_R8: assert property (@(posedge clk) disable iff (!rstN)
    batchDone |-> (pathCount != '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accLoad |=> ($stable(asianSum) && $stable(barrierSum) && $stable(pathCount)));

endmodule

bind asian_barrier_payoff payoff_checker u_chk (.*);

// File: tb/tb_asian_barrier_payoff.sv
module tb_asian_barrier_payoff;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        priceValid = 1'b0;
  logic [31:0] price = '0;
  logic        lastStep = 1'b0;
  logic        lastPath = 1'b0;
  logic [31:0] strike = 32'd8519680;     // 130.0
  logic [31:0] barrier = 32'h00A2_8000;  // 162.5
  logic [31:0] avgRecip = 32'h4000_0000; // 1/4
  logic [63:0] asianSum, barrierSum;
  logic [31:0] pathCount;
  logic        batchDone;

  always #10 clk = ~clk;  // 50 MHz

  asian_barrier_payoff dut (
    .clk(clk), .rstN(rstN), .priceValid(priceValid), .price(price),
    .lastStep(lastStep), .lastPath(lastPath), .strike(strike),
    .barrier(barrier), .avgRecip(avgRecip), .asianSum(asianSum),
    .barrierSum(barrierSum), .pathCount(pathCount), .batchDone(batchDone)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit cmpOn = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: path state, a two-slot delay of closed-path
  // payoffs and the batch totals
  logic [47:0] mSum;
  bit          mHit, mFirst;
  bit          q1v, q1l, q2v, q2l;
  logic [31:0] q1a, q1b, q2a, q2b;
  logic [63:0] eAsian, eBarrier;
  logic [31:0] eCount;
  bit          eDone, eFresh;

  always @(posedge clk) begin
    if (!rstN) begin
      mSum = '0; mHit = 0; mFirst = 1;
      q1v = 0; q2v = 0; q1l = 0; q2l = 0; q1a = '0; q1b = '0; q2a = '0; q2b = '0;
      eAsian = '0; eBarrier = '0; eCount = '0; eDone = 0; eFresh = 1;
    end else begin
      eDone = 0;
      if (q2v) begin
        if (eFresh) begin
          eAsian = 64'(q2a); eBarrier = 64'(q2b); eCount = 1;
        end else begin
          eAsian += 64'(q2a); eBarrier += 64'(q2b); eCount += 1;
        end
        eDone = q2l;
        eFresh = q2l;
      end
      q2v = q1v; q2l = q1l; q2a = q1a; q2b = q1b;
      q1v = 0; q1l = 0;
      if (priceValid) begin
        logic [95:0] prod;
        logic [31:0] avg;
        if (mFirst) begin mSum = '0; mHit = 0; end
        mSum += 48'(price);
        if (price >= barrier) mHit = 1;
        mFirst = lastStep;
        if (lastStep) begin
          prod = 96'(mSum) * 96'(avgRecip);
          avg  = prod[63:32];
          q1v = 1; q1l = lastPath;
          q1a = (avg > strike) ? avg - strike : '0;
          q1b = (mHit && price > strike) ? price - strike : '0;
        end
      end
    end
  end

  // Compared on every clock, away from the active edge (R7, R9)
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      chk(asianSum == eAsian, "R7", "cycle asianSum", asianSum, eAsian);
      chk(barrierSum == eBarrier, "R7", "cycle barrierSum", barrierSum, eBarrier);
      chk(pathCount == eCount, "R9", "cycle pathCount", pathCount, eCount);
      chk(batchDone == eDone, "R8", "cycle batchDone", batchDone, eDone);
    end
  end

  task automatic step(input logic [31:0] p, input bit ls, input bit lp);
    @(negedge clk);
    priceValid = 1; price = p; lastStep = ls; lastPath = lp;
  endtask

  task automatic idle();
    @(negedge clk);
    priceValid = 0; lastStep = 0; lastPath = 0; price = 32'hDEAD_BEEF;
  endtask

  localparam logic [31:0] ONE = 32'd65536;

  // Four-step paths, prices in Q16.16
  task automatic pathA(input bit lp);  // touches the barrier exactly
    step(150 * ONE, 0, 0); step(32'h00A2_8000, 0, 0);
    step(140 * ONE, 0, 0); step(160 * ONE, 1, lp);
  endtask
  task automatic pathB(input bit lp);  // one LSB below the barrier
    step(150 * ONE, 0, 0); step(32'h00A2_7FFF, 0, 0);
    step(140 * ONE, 0, 0); step(160 * ONE, 1, lp);
  endtask
  task automatic pathC(input bit lp);  // hits on the last step, mean below strike
    step(100 * ONE, 0, 0); step(110 * ONE, 0, 0);
    step(120 * ONE, 0, 0); step(170 * ONE, 1, lp);
  endtask
  task automatic pathD(input bit lp);  // hits early, ends below strike
    step(170 * ONE, 0, 0); step(165 * ONE, 0, 0);
    step(120 * ONE, 0, 0); step(100 * ONE, 1, lp);
  endtask

  // After the closing step: idle, then two more falling edges reach the
  // cycle after the second edge past acceptance
  task automatic waitResult();
    idle();
    repeat (2) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] rs;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(asianSum == 0, "R10", "reset asianSum", asianSum, 0);
    chk(barrierSum == 0, "R10", "reset barrierSum", barrierSum, 0);
    chk(pathCount == 0 && batchDone == 0, "R10", "reset count/done", pathCount, 0);
    rstN = 1;
    cmpOn = 1;

    // R3: price equal to the barrier counts as a hit
    pathA(1); waitResult();
    chk(batchDone == 1, "R8", "done pulse A", batchDone, 1);
    chk(barrierSum == 30 * ONE, "R3", "exact touch barrier payoff", barrierSum, 30 * ONE);
    chk(asianSum == 1515520, "R4", "A asian payoff", asianSum, 1515520);
    chk(pathCount == 1, "R10", "first path after reset", pathCount, 1);
    @(negedge clk);
    chk(batchDone == 0, "R8", "done lasts one cycle", batchDone, 0);
    chk(asianSum == 1515520, "R9", "hold after batch", asianSum, 1515520);

    // R5, R2: just below the barrier; mean truncation
    pathB(1); waitResult();
    chk(barrierSum == 0, "R5", "no hit barrier payoff", barrierSum, 0);
    chk(asianSum == 1515519, "R2", "truncated mean payoff", asianSum, 1515519);
    chk(pathCount == 1, "R8", "new batch count", pathCount, 1);

    // R4: mean below strike gives zero Asian payoff
    pathC(1); waitResult();
    chk(asianSum == 0, "R4", "mean below strike", asianSum, 0);
    chk(barrierSum == 40 * ONE, "R3", "hit on last step", barrierSum, 40 * ONE);

    // R5: hit but final price below strike
    pathD(1); waitResult();
    chk(barrierSum == 0, "R5", "final below strike", barrierSum, 0);
    chk(asianSum == 573440, "R4", "D asian payoff", asianSum, 573440);

    // R1, R6, R7: back-to-back paths; C hits then B must not inherit it
    pathA(0); pathC(0); pathB(0); pathD(1); waitResult();
    chk(pathCount == 4, "R7", "batch count", pathCount, 4);
    chk(asianSum == 3604479, "R7", "batch asian sum", asianSum, 3604479);
    chk(barrierSum == 4587520, "R6", "no hit carried between paths", barrierSum, 4587520);

    // R1: idle cycles inside a path change nothing
    step(150 * ONE, 0, 0); idle(); step(32'h00A2_8000, 0, 0); idle(); idle();
    step(140 * ONE, 0, 0); step(160 * ONE, 1, 1); waitResult();
    chk(asianSum == 1515520, "R1", "gapped path asian", asianSum, 1515520);
    chk(barrierSum == 30 * ONE, "R1", "gapped path barrier", barrierSum, 30 * ONE);

    // R2: 252-step path at a constant price of 131.0
    idle();
    avgRecip = 32'd17043521;
    for (int i = 0; i < 252; i++) step(131 * ONE, i == 251, i == 251);
    waitResult();
    chk(asianSum == 65535, "R2", "252-step mean payoff", asianSum, 65535);
    chk(barrierSum == 0, "R5", "252-step no hit", barrierSum, 0);

    // Pseudo-random batch of 20 eight-step paths, checked by the model
    idle();
    avgRecip = 32'h2000_0000;
    rs = 32'h1234_5678;
    for (int pth = 0; pth < 20; pth++) begin
      for (int s = 0; s < 8; s++) begin
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        step(((32'd115 + (rs % 32'd55)) << 16) | {16'd0, rs[15:0]}, s == 7, pth == 19);
        if (rs[20] && s != 7) idle();
      end
    end
    waitResult();
    chk(pathCount == 20, "R7", "random batch count", pathCount, 20);
    repeat (4) @(negedge clk);
    chk(pathCount == 20, "R9", "hold when idle", pathCount, 20);

    cmpOn = 0;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule